// File: doc/BRIEF.md
# Dual-Slot SD Host Register Wrapper

This block sits between a 32-bit register bus and two SD host controller slots. It decodes a 4 KiB window. The lowest 256 bytes hold the wrapper's own word bank. The next 256-byte pages are handed to the slots, one page per slot. Any offset above the last slot page is rejected.

The wrapper bank does three jobs:
- It acts as plain read/write storage.
- It carries writable copies of each slot's capability and maximum-current values. These copies drive the slots directly.
- It holds an interrupt status word. That word follows the slot interrupt lines and feeds one shared interrupt output.

A bus read is answered one cycle after it is issued, whether the data comes from the wrapper bank or from a slot. Only whole 32-bit words are accessed. The word is selected by address bits 7:2.

Top module: `sdwrap_top`

## Requirements
- R1: After reset, word 0x00 reads 0x00030000 and word 0x04 reads 0x00000005. Every other plain wrapper word and the status word read 0. Each slot's maximum-current copy reads 0, and irqOut is low.
- R2: Every wrapper word at offsets 0x00–0xF8 that is not a slot alias keeps the last 32-bit value written to it, and reads it back.
- R3: Offsets 0x10 and 0x18 are slot 0's capability and maximum-current copies; 0x20 and 0x28 are slot 1's. Each capability copy resets to 0x01E80080. A write to a copy appears on slotCap or slotMaxCurr (slot n in bits 32n+31:32n) one cycle after the request, and reads back.
- R4: A request at offset 0x100·(n+1)+k raises only slotSel bit n, in the request cycle. slotAddr carries k (8 bits), and slotWrite and slotWdata carry the bus values. No wrapper word changes.
- R5: busRvalid is high exactly in the cycle after each read request. In that cycle busRdata holds the addressed word; for a slot read it holds that slot's slotRdata lane in that cycle.
- R6: Bit n of the status word at 0xFC equals slotIrq[n] as sampled at the previous clock edge. Its upper bits read 0. A read of 0xFC returns the status held before the request's edge.
- R7: irqOut is the OR of the status bits. Lowering one slot's line leaves irqOut high while the other slot's bit is set.
- R8: A bus write to 0xFC has no effect on the status word or on irqOut, including when it lands in the same cycle as a change on slotIrq.
- R9: A request at offset 0x300 or above stores nothing, selects no slot and reads back 0. It pulses errEvent high for the one cycle after the request.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset in the window |
| busWdata | input | 32 | Write data |
| busRvalid | output | 1 | Read data valid (cycle after a read) |
| busRdata | output | 32 | Read data |
| errEvent | output | 1 | Out-of-range access flag |
| slotSel | output | 2 | One-hot slot select strobe |
| slotWrite | output | 1 | Write flag to slots |
| slotAddr | output | 8 | Slot-relative byte offset |
| slotWdata | output | 32 | Write data to slots |
| slotRdata | input | 64 | Slot read data, slot n in bits 32n+31:32n |
| slotIrq | input | 2 | Slot interrupt levels |
| irqOut | output | 1 | Shared interrupt |
| slotCap | output | 64 | Capability copies, per slot |
| slotMaxCurr | output | 64 | Maximum-current copies, per slot |

## Verification
Two things can happen in the same clock cycle: an edge on a slot interrupt line and a bus access to the status word. The bench drives the new slotIrq level together with the request, so both are sampled by the same edge.

A write of all ones to 0xFC in that cycle must leave the status equal to the new interrupt levels. A read in that cycle must return the levels from before the edge. Both cases are judged through later status reads and irqOut.

// File: rtl/sdwrap_pkg.sv
package sdwrap_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int PAGE_W     = 8;
  localparam int WORD_BITS  = PAGE_W - 2;
  localparam int NUM_WORDS  = 1 << WORD_BITS;
  localparam int REGION_W   = ADDR_W - PAGE_W;
  localparam int STATUS_IDX = NUM_WORDS - 1;
  localparam int INFO_IDX   = 0;
  localparam int DEB_IDX    = 1;
  localparam int ALIAS_BASE   = 4;
  localparam int ALIAS_STRIDE = 4;
  localparam int MAXC_PHASE   = 2;

  typedef struct packed {
    logic                 wrapWr;
    logic                 wrapRd;
    logic [WORD_BITS-1:0] wordIdx;
  } wrapCtl_t;
endpackage

// File: rtl/sdwrap_ctrl.sv
module sdwrap_ctrl
  import sdwrap_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  output wrapCtl_t             ctl,
  output logic [NUM_SLOTS-1:0] slotSel,
  output logic [PAGE_W-1:0]    slotAddr,
  output logic [NUM_SLOTS-1:0] rspSlotHit,
  output logic                 rspValid,
  output logic                 errEvent
);
  logic [REGION_W-1:0]  region;
  logic                 isWrap;
  logic [NUM_SLOTS-1:0] slotHit;
  logic                 isErr;

  assign region = busAddr[ADDR_W-1:PAGE_W];
  assign isWrap = (region == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign slotHit[s] = (region == REGION_W'(s + 1));
  end

  assign isErr = !isWrap && !(|slotHit);

  always_comb begin
    ctl.wrapWr  = busReq && busWrite && isWrap;
    ctl.wrapRd  = busReq && !busWrite && isWrap;
    ctl.wordIdx = busAddr[PAGE_W-1:2];
  end

  assign slotSel  = busReq ? slotHit : '0;
  assign slotAddr = busAddr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspSlotHit <= '0;
      errEvent   <= 1'b0;
    end else begin
      rspValid   <= busReq && !busWrite;
      rspSlotHit <= (busReq && !busWrite) ? slotHit : '0;
      errEvent   <= busReq && isErr;
    end
  end
endmodule

// File: rtl/sdwrap_datapath.sv
module sdwrap_datapath
  import sdwrap_pkg::*;
#(
  parameter int                NUM_SLOTS      = 2,
  parameter logic [DATA_W-1:0] CAP_RESET      = 32'h01E8_0080,
  parameter logic [DATA_W-1:0] INFO_RESET     = 32'h0003_0000,
  parameter logic [DATA_W-1:0] DEBOUNCE_RESET = 32'h0000_0005
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  wrapCtl_t                    ctl,
  input  logic [DATA_W-1:0]           busWdata,
  input  logic [NUM_SLOTS-1:0]        rspSlotHit,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  input  logic [NUM_SLOTS-1:0]        slotIrq,
  output logic [DATA_W-1:0]           busRdata,
  output logic [NUM_SLOTS*DATA_W-1:0] slotCap,
  output logic [NUM_SLOTS*DATA_W-1:0] slotMaxCurr,
  output logic                        irqOut
);
  logic [DATA_W-1:0]    wordView [NUM_WORDS];
  logic [DATA_W-1:0]    capReg   [NUM_SLOTS];
  logic [DATA_W-1:0]    maxReg   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] statusReg;
  logic [DATA_W-1:0]    statusWord;
  logic [DATA_W-1:0]    rdWrap;
  logic [DATA_W-1:0]    rdSlot;

  // Interrupt levels mirrored; bus writes never reach this register.
  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= slotIrq;
  end
  assign statusWord = {{(DATA_W-NUM_SLOTS){1'b0}}, statusReg};
  assign irqOut     = |statusReg;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_alias
    localparam int CAP_IDX  = ALIAS_BASE + ALIAS_STRIDE * s;
    localparam int MAXC_IDX = CAP_IDX + MAXC_PHASE;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        capReg[s] <= CAP_RESET;
        maxReg[s] <= '0;
      end else if (ctl.wrapWr) begin
        if (ctl.wordIdx == WORD_BITS'(CAP_IDX))  capReg[s] <= busWdata;
        if (ctl.wordIdx == WORD_BITS'(MAXC_IDX)) maxReg[s] <= busWdata;
      end
    end
    assign slotCap[s*DATA_W +: DATA_W]     = capReg[s];
    assign slotMaxCurr[s*DATA_W +: DATA_W] = maxReg[s];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int  REL      = w - ALIAS_BASE;
    localparam int  SLOT_OF  = (REL >= 0) ? REL / ALIAS_STRIDE : 0;
    localparam int  PHASE    = (REL >= 0) ? REL % ALIAS_STRIDE : 1;
    localparam bit  IN_ALIAS = (REL >= 0) && (SLOT_OF < NUM_SLOTS);
    localparam logic [DATA_W-1:0] RST_VAL =
      (w == INFO_IDX) ? INFO_RESET : (w == DEB_IDX) ? DEBOUNCE_RESET : '0;
    if (w == STATUS_IDX) begin : g_status
      assign wordView[w] = statusWord;
    end else if (IN_ALIAS && PHASE == 0) begin : g_cap
      assign wordView[w] = capReg[SLOT_OF];
    end else if (IN_ALIAS && PHASE == MAXC_PHASE) begin : g_maxc
      assign wordView[w] = maxReg[SLOT_OF];
    end else begin : g_plain
      logic [DATA_W-1:0] store;
      always_ff @(posedge clk) begin
        if (!rstN) store <= RST_VAL;
        else if (ctl.wrapWr && ctl.wordIdx == WORD_BITS'(w)) store <= busWdata;
      end
      assign wordView[w] = store;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdWrap <= '0;
    else if (ctl.wrapRd) rdWrap <= wordView[ctl.wordIdx];
    else                 rdWrap <= '0;
  end

  always_comb begin
    rdSlot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rspSlotHit[s]) rdSlot = rdSlot | slotRdata[s*DATA_W +: DATA_W];
    end
  end

  assign busRdata = (|rspSlotHit) ? rdSlot : rdWrap;
endmodule

// File: rtl/sdwrap_top.sv
module sdwrap_top
  import sdwrap_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busReq,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWdata,
  output logic                        busRvalid,
  output logic [DATA_W-1:0]           busRdata,
  output logic                        errEvent,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic                        slotWrite,
  output logic [PAGE_W-1:0]           slotAddr,
  output logic [DATA_W-1:0]           slotWdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  input  logic [NUM_SLOTS-1:0]        slotIrq,
  output logic                        irqOut,
  output logic [NUM_SLOTS*DATA_W-1:0] slotCap,
  output logic [NUM_SLOTS*DATA_W-1:0] slotMaxCurr
);
  wrapCtl_t             ctl;
  logic [NUM_SLOTS-1:0] rspSlotHit;

  assign slotWrite = busWrite;
  assign slotWdata = busWdata;

  sdwrap_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .ctl(ctl), .slotSel(slotSel), .slotAddr(slotAddr),
    .rspSlotHit(rspSlotHit), .rspValid(busRvalid), .errEvent(errEvent)
  );

  sdwrap_datapath #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata),
    .rspSlotHit(rspSlotHit), .slotRdata(slotRdata), .slotIrq(slotIrq),
    .busRdata(busRdata), .slotCap(slotCap), .slotMaxCurr(slotMaxCurr),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/sdwrap_checker.sv
module sdwrap_checker
  import sdwrap_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busReq,
  input logic                        busWrite,
  input logic [ADDR_W-1:0]           busAddr,
  input logic                        busRvalid,
  input logic                        errEvent,
  input logic [NUM_SLOTS-1:0]        slotSel,
  input logic [NUM_SLOTS-1:0]        slotIrq,
  input logic                        irqOut,
  input logic [NUM_SLOTS*DATA_W-1:0] slotCap,
  input logic [NUM_SLOTS*DATA_W-1:0] slotMaxCurr
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |=> busRvalid); // R5
  AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && busRvalid) |-> $past(busReq && !busWrite)); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel)); // R4
  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|slotSel) |-> busReq); // R4
  AST_IRQ_FOLLOWS_LINES: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (irqOut == (|$past(slotIrq)))); // R7
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && errEvent) |->
      ($past(busReq) && ($past(busAddr[ADDR_W-1:PAGE_W]) > REGION_W'(NUM_SLOTS)))); // R9
  AST_ALIAS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!(busReq && busWrite))) |->
      ($stable(slotCap) && $stable(slotMaxCurr))); // R3
endmodule

bind sdwrap_top sdwrap_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busRvalid(busRvalid), .errEvent(errEvent),
  .slotSel(slotSel), .slotIrq(slotIrq), .irqOut(irqOut),
  .slotCap(slotCap), .slotMaxCurr(slotMaxCurr)
);

// File: tb/test_sdwrap_top.sv
`timescale 1ns/1ps
module test_sdwrap_top;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busReq = 1'b0, busWrite = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic          busRvalid, errEvent, slotWrite, irqOut;
  logic [31:0]   busRdata, slotWdata;
  logic [NS-1:0] slotSel;
  logic [7:0]    slotAddr;
  logic [NS*32-1:0] slotRdata = '0, slotCap, slotMaxCurr;
  logic [NS-1:0] slotIrq = '0;
  logic [NS-1:0] irqDrive = '0;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  sdwrap_top #(.NUM_SLOTS(NS)) i_sdwrap_top (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRvalid(busRvalid),
    .busRdata(busRdata), .errEvent(errEvent), .slotSel(slotSel),
    .slotWrite(slotWrite), .slotAddr(slotAddr), .slotWdata(slotWdata),
    .slotRdata(slotRdata), .slotIrq(slotIrq), .irqOut(irqOut),
    .slotCap(slotCap), .slotMaxCurr(slotMaxCurr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access; slotIrq takes irqDrive in the request cycle.
  task automatic busOp(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic rv, output logic er,
                       output logic [NS-1:0] sel, output logic [7:0] sa,
                       output logic sw, output logic [31:0] swd);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busWdata = d; slotIrq = irqDrive;
    #1;
    sel = slotSel; sa = slotAddr; sw = slotWrite; swd = slotWdata;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
    rd = busRdata; rv = busRvalid; er = errEvent;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd, swd; logic rv, er, sw; logic [NS-1:0] sel; logic [7:0] sa;
    busOp(1'b1, a, d, rd, rv, er, sel, sa, sw, swd);
  endtask

  task automatic rdCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd, swd; logic rv, er, sw; logic [NS-1:0] sel; logic [7:0] sa;
    busOp(1'b0, a, 32'h0, rd, rv, er, sel, sa, sw, swd);
    check({tag, " rvalid"}, 32'(rv), 32'd1);
    check({tag, " rdata"}, rd, exp);
  endtask

  function automatic bit isAlias(input int w);
    return (w == 4) || (w == 6) || (w == 8) || (w == 10);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, swd; logic rv, er, sw; logic [NS-1:0] sel; logic [7:0] sa;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 / R3: reset sweep
    for (int w = 0; w < 64; w++) begin
      model[w] = (w == 0) ? 32'h0003_0000 : (w == 1) ? 32'h5 :
                 (w == 4 || w == 8) ? 32'h01E8_0080 : 32'h0;
    end
    check("R1 irqOut reset", 32'(irqOut), 0);
    check("R3 cap0 reset", slotCap[31:0], 32'h01E8_0080);
    check("R3 cap1 reset", slotCap[63:32], 32'h01E8_0080);
    check("R1 maxcurr reset", slotMaxCurr, '0);
    for (int w = 0; w < 64; w++) rdCheck("R1 reset word", 12'(w * 4), model[w]);

    // R2 / R3 / R8: write every word, read all back
    for (int w = 0; w < 64; w++) begin
      logic [31:0] p;
      p = {8'h5A, 8'(w), ~8'(w), 8'hC3};
      wr(12'(w * 4), p);
      if (w != 63) model[w] = p;
    end
    for (int w = 0; w < 64; w++)
      rdCheck(isAlias(w) ? "R3 alias readback" : (w == 63) ? "R8 status write ignored"
              : "R2 plain readback", 12'(w * 4), model[w]);
    check("R3 cap0 out", slotCap[31:0], model[4]);
    check("R3 max0 out", slotMaxCurr[31:0], model[6]);
    check("R3 cap1 out", slotCap[63:32], model[8]);
    check("R3 max1 out", slotMaxCurr[63:32], model[10]);

    // R2: walking ones on bus word 0x08
    for (int b = 0; b < 32; b++) begin
      wr(12'h008, 32'h1 << b);
      rdCheck("R2 walking one", 12'h008, 32'h1 << b);
    end
    model[2] = 32'h8000_0000;

    // R3: alias output changes one cycle after request
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = 12'h020; busWdata = 32'hCAFE_0001;
    #1 check("R3 cap1 before edge", slotCap[63:32], model[8]);
    @(negedge clk); busReq = 1'b0; busWrite = 1'b0;
    check("R3 cap1 after edge", slotCap[63:32], 32'hCAFE_0001);
    model[8] = 32'hCAFE_0001;

    // R4 / R5: slot forwarding
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 256; k += 36) begin
        logic [11:0] a;
        a = 12'((s + 1) * 256 + k);
        busOp(1'b1, a, 32'hD000_0000 | 32'(k), rd, rv, er, sel, sa, sw, swd);
        check("R4 write sel", 32'(sel), 32'(1 << s));
        check("R4 slot addr", 32'(sa), 32'(k & 8'hFC));
        check("R4 slot write", 32'(sw), 1);
        check("R4 slot wdata", swd, 32'hD000_0000 | 32'(k));
        slotRdata = {32'hB100_0000 | 32'(k), 32'hA000_0000 | 32'(k)};
        busOp(1'b0, a, 32'h0, rd, rv, er, sel, sa, sw, swd);
        check("R4 read sel", 32'(sel), 32'(1 << s));
        check("R5 slot rvalid", 32'(rv), 1);
        check("R5 slot rdata", rd, slotRdata[s*32 +: 32]);
      end
    end
    for (int w = 0; w < 64; w++) rdCheck("R4 wrapper untouched", 12'(w * 4), model[w]);

    // R9: out-of-range
    for (int k = 0; k < 13; k++) begin
      logic [11:0] a;
      a = 12'h300 + 12'(k * 12'h0D4);
      busOp(1'b1, a, 32'hFFFF_FFFF, rd, rv, er, sel, sa, sw, swd);
      check("R9 err on write", 32'(er), 1);
      check("R9 no sel", 32'(sel), 0);
      busOp(1'b0, a, 32'h0, rd, rv, er, sel, sa, sw, swd);
      check("R9 err on read", 32'(er), 1);
      check("R9 read zero", rd, 0);
      rdCheck("R9 alias word kept", {4'h0, a[7:0]}, model[a[7:2]]);
    end
    busOp(1'b0, 12'h004, 32'h0, rd, rv, er, sel, sa, sw, swd);
    check("R9 no err in range", 32'(er), 0);

    // R6 / R7: interrupt levels
    for (int v = 0; v < 4; v++) begin
      irqDrive = NS'(v);
      @(negedge clk); slotIrq = irqDrive;
      @(negedge clk);
      check("R7 irqOut", 32'(irqOut), 32'(v != 0));
      rdCheck("R6 status", 12'h0FC, 32'(v));
    end
    irqDrive = 2'b11; @(negedge clk); slotIrq = irqDrive; @(negedge clk);
    irqDrive = 2'b10; @(negedge clk); slotIrq = irqDrive; @(negedge clk);
    check("R7 other slot keeps irq", 32'(irqOut), 1);
    rdCheck("R6 status one dropped", 12'h0FC, 32'h2);

    // R8: status write collides with irq change
    irqDrive = 2'b01;
    wr(12'h0FC, 32'hFFFF_FFFF);
    check("R8 irq after collide", 32'(irqOut), 1);
    rdCheck("R8 status after collide", 12'h0FC, 32'h1);
    irqDrive = 2'b00;
    wr(12'h0FC, 32'hFFFF_FFFF);
    check("R8 irq low after write", 32'(irqOut), 0);
    // R6: read in the cycle of a change returns the earlier level
    irqDrive = 2'b10;
    rdCheck("R6 read old status", 12'h0FC, 32'h0);
    rdCheck("R6 read new status", 12'h0FC, 32'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule